// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts every lane of a 128-bit operand vector by an amount carried in the matching lane of a second vector. The amount is the signed low byte of that lane. A positive amount shifts left and a negative amount shifts right by its magnitude. Lanes can be 8, 16, 32 or 64 bits wide. Control inputs choose how the lane data is read (signed or unsigned), how right shifts end (rounded or truncated), and how left overflow is handled (clamped or wrapped). A half-register option processes only the low 64 bits.

Each accepted vector produces a registered result one clock later. When any active lane clamps, the block raises a one-cycle saturation pulse. It also ORs that pulse into a sticky flag, which stays set until an explicit clear. A surrounding execution pipeline issues one operation per `in_valid` and collects `result` on `out_valid`.

Top module: `vshift_unit`

## Requirements
- R1: The shift amount of a lane is bits [7:0] of that lane of `opnd_b`, read as a two's-complement value from -128 to +127. All higher bits of the lane have no effect on the result or on saturation.
- R2: An amount of zero returns the lane unchanged. A negative amount shifts right by its magnitude: arithmetically when `is_signed`=1 and logically when `is_signed`=0.
- R3: With `sat_en`=0, a positive amount below the lane width gives the left-shifted value truncated to the lane width. A positive amount at or above the width gives zero, and no saturation is reported.
- R4: With `round_en`=0, a right shift whose magnitude is at least the lane width gives all ones for a negative signed lane. It gives zero for a non-negative signed lane and for any unsigned lane.
- R5: With `round_en`=1, a right shift by m first adds 2^(m-1) and then shifts, with the sum held one bit wider than the lane so that no carry is lost. For signed lanes, m at or above the width gives zero. For unsigned lanes, m equal to the width gives the lane's top bit, and m above the width gives zero.
- R6: With `sat_en`=1, a left shift whose exact result does not fit the lane clamps and reports saturation. Signed lanes clamp to the signed maximum for a positive input and to the signed minimum for a negative input. Unsigned lanes clamp to all ones. Amounts at or above the lane width clamp every nonzero input.
- R7: A lane whose input is zero never clamps and never contributes to saturation, for every amount and mode.
- R8: With `half_form`=1, only lanes inside bits [63:0] are processed. Result bits [127:64] are zero, and upper lanes cannot cause saturation.
- R9: `lane_size` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies bits [i*W +: W].
- R10: `out_valid` and `result` follow `in_valid` by exactly one clock. `result` holds its value while `in_valid` is low. `sat_pulse` is high only in a cycle with `out_valid` and only when some active lane clamped.
- R11: `sat_sticky` becomes set in the same cycle as `sat_pulse` and stays set until a cycle with `sat_clear`=1 and no new pulse. A pulse in the clearing cycle keeps the flag set. Synchronous reset clears `out_valid`, `result`, `sat_pulse` and `sat_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_size | input | 2 | Lane width code (8/16/32/64) |
| is_signed | input | 1 | Lane data is two's complement |
| round_en | input | 1 | Round right shifts instead of truncating |
| sat_en | input | 1 | Clamp left-shift overflow instead of wrapping |
| half_form | input | 1 | Process low 64 bits only, zero the upper half |
| opnd_a | input | 128 | Data vector |
| opnd_b | input | 128 | Shift-amount vector (signed low byte of each lane) |
| sat_clear | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Shifted vector |
| sat_pulse | output | 1 | One-cycle indication that a lane clamped |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
The lane checks assume known operand and control values once they are evaluated. The clocked checks assume that `in_valid` and `sat_clear` are never X after reset. The bench drives every input to a defined value from time zero and changes inputs only on the falling clock edge, so each registered stage sees stable, known data. The sweep covers every amount from -128 to +127 for each lane width and each combination of sign, rounding and saturation. Each lane carries zero, signed maximum, signed minimum, all-ones, one or a scrambled value, and the unused amount bits carry noise.

// File: rtl/vsh_pkg.sv
`timescale 1ns/1ps
package vsh_pkg;
  localparam int AMT_W = 8;
  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_size_e;
endpackage

// File: rtl/vsh_lane.sv
`timescale 1ns/1ps
module vsh_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0]            a_i,
  input  logic [vsh_pkg::AMT_W-1:0] amt_i,
  input  logic                    signed_i,
  input  logic                    round_i,
  input  logic                    sat_i,
  output logic [W-1:0]            res_o,
  output logic                    sat_o
);
  localparam int EW = W + 1;
  localparam logic [7:0] W8 = 8'(W);

  logic signed [7:0]  amt;
  logic [7:0]         mag;
  logic [6:0]         lsh;
  logic [W-1:0]       shl;
  logic [W-1:0]       back;
  logic               over;
  logic [W:0]         rc;
  logic signed [W:0]  ext;
  logic signed [W:0]  sum;
  logic signed [W:0]  rsh;
  logic [W-1:0]       clamp;

  assign amt = amt_i;
  assign ext = {signed_i & a_i[W-1], a_i};
  assign clamp = signed_i ? (a_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                          : {W{1'b1}};

  always_comb begin
    res_o = a_i;
    sat_o = 1'b0;
    mag   = -amt;
    lsh   = amt[6:0];
    shl   = '0;
    back  = '0;
    over  = 1'b0;
    rc    = '0;
    sum   = '0;
    rsh   = '0;
    if (amt > 0) begin
      if ({1'b0, lsh} >= W8) begin
        over = |a_i;
      end else begin
        shl  = a_i << lsh;
        back = signed_i ? W'($signed(shl) >>> lsh) : (shl >> lsh);
        over = (back != a_i);
      end
      if (sat_i && over) begin
        res_o = clamp;
        sat_o = 1'b1;
      end else begin
        res_o = shl;
      end
    end else if (amt < 0) begin
      if (round_i) begin
        if (mag > W8) begin
          res_o = '0;
        end else begin
          rc    = EW'(1) << (mag - 8'd1);
          sum   = ext + $signed(rc);
          rsh   = signed_i ? (sum >>> mag) : (sum >> mag);
          res_o = rsh[W-1:0];
        end
      end else begin
        if (mag >= W8) begin
          res_o = signed_i ? {W{a_i[W-1]}} : '0;
        end else begin
          res_o = signed_i ? W'($signed(a_i) >>> mag) : (a_i >> mag);
        end
      end
    end
  end

  always_comb begin
    if (!$isunknown({a_i, amt_i, signed_i, round_i, sat_i})) begin
      assert_zero_never_clamps_R7: assert (!((a_i == '0) && sat_o));
      assert_unsigned_clamp_ones_R6: assert (!(sat_o && !signed_i) || (res_o == {W{1'b1}}));
      assert_clamp_only_left_R6: assert (!sat_o || (sat_i && (amt > 0)));
    end
  end
endmodule

// File: rtl/vsh_lane_bank.sv
`timescale 1ns/1ps
module vsh_lane_bank #(
  parameter int VEC_W = 128,
  parameter int W     = 8,
  localparam int LANES = VEC_W / W,
  localparam int AW    = vsh_pkg::AMT_W
) (
  input  logic [VEC_W-1:0]    a_i,
  input  logic [LANES*AW-1:0] amt_i,
  input  logic                signed_i,
  input  logic                round_i,
  input  logic                sat_i,
  input  logic                half_i,
  output logic [VEC_W-1:0]    res_o,
  output logic                sat_o
);
  logic [LANES-1:0] lane_sat;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit IS_UPPER = (g >= LANES / 2);
    logic [W-1:0] lres;
    logic         lsat;
    logic         off;

    vsh_lane #(.W(W)) u_lane (
      .a_i      (a_i[g*W +: W]),
      .amt_i    (amt_i[g*AW +: AW]),
      .signed_i (signed_i),
      .round_i  (round_i),
      .sat_i    (sat_i),
      .res_o    (lres),
      .sat_o    (lsat)
    );

    assign off            = IS_UPPER && half_i;
    assign res_o[g*W +: W] = off ? '0 : lres;
    assign lane_sat[g]    = lsat && !off;
  end

  assign sat_o = |lane_sat;
endmodule

// File: rtl/vsh_sat_flag.sv
`timescale 1ns/1ps
module vsh_sat_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic sticky_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o  <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      pulse_o  <= evt_i;
      sticky_o <= (sticky_o && !clr_i) || evt_i;
    end
  end

  assert_sticky_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (sticky_o && !clr_i) |=> sticky_o);
  assert_sticky_with_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> sticky_o);
  assert_clear_drops_R11: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !evt_i) |=> !sticky_o);
endmodule

// File: rtl/vshift_unit.sv
`timescale 1ns/1ps
module vshift_unit #(
  parameter int VEC_W     = 128,
  parameter int NUM_SIZES = 4,
  parameter int BASE_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       lane_size,
  input  logic             is_signed,
  input  logic             round_en,
  input  logic             sat_en,
  input  logic             half_form,
  input  logic [VEC_W-1:0] opnd_a,
  input  logic [VEC_W-1:0] opnd_b,
  input  logic             sat_clear,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             sat_pulse,
  output logic             sat_sticky
);
  import vsh_pkg::*;
  localparam int AW   = AMT_W;
  localparam int HALF = VEC_W / 2;

  lane_size_e       sz;
  logic [VEC_W-1:0] bank_res [NUM_SIZES];
  logic             bank_sat [NUM_SIZES];
  logic [VEC_W-1:0] sel_res;
  logic             sel_sat;

  assign sz = lane_size_e'(lane_size);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int LW = BASE_W << k;
    localparam int NL = VEC_W / LW;
    logic [NL*AW-1:0] amt_k;

    for (genvar j = 0; j < NL; j++) begin : g_amt
      assign amt_k[j*AW +: AW] = opnd_b[j*LW +: AW];
    end

    vsh_lane_bank #(.VEC_W(VEC_W), .W(LW)) u_bank (
      .a_i      (opnd_a),
      .amt_i    (amt_k),
      .signed_i (is_signed),
      .round_i  (round_en),
      .sat_i    (sat_en),
      .half_i   (half_form),
      .res_o    (bank_res[k]),
      .sat_o    (bank_sat[k])
    );
  end

  assign sel_res = bank_res[sz];
  assign sel_sat = bank_sat[sz];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= sel_res;
    end
  end

  vsh_sat_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (in_valid && sel_sat),
    .clr_i    (sat_clear),
    .pulse_o  (sat_pulse),
    .sticky_o (sat_sticky)
  );

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));
  assert_pulse_qualified_R10: assert property (@(posedge clk) disable iff (rst)
    sat_pulse |-> out_valid);
  assert_half_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && half_form) |=> (result[VEC_W-1:HALF] == '0));
endmodule

// File: tb/vshift_unit_bench.sv
`timescale 1ns/1ps
module vshift_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   lane_size = 2'd0;
  logic         is_signed = 1'b0;
  logic         round_en = 1'b0;
  logic         sat_en = 1'b0;
  logic         half_form = 1'b0;
  logic [127:0] opnd_a = '0;
  logic [127:0] opnd_b = '0;
  logic         sat_clear = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         sat_pulse;
  logic         sat_sticky;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vshift_unit u_vshift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_size(lane_size),
    .is_signed(is_signed), .round_en(round_en), .sat_en(sat_en),
    .half_form(half_form), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .sat_clear(sat_clear), .out_valid(out_valid), .result(result),
    .sat_pulse(sat_pulse), .sat_sticky(sat_sticky)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] lmask(input int w);
    return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  // Pure arithmetic model on a very wide signed number
  function automatic void ref_lane(input int w, input logic [63:0] a, input logic signed [7:0] s,
                                   input bit sg, input bit rnd, input bit sat,
                                   output logic [63:0] r, output bit q);
    logic signed [199:0] v, t, hi, lo, one;
    int m;
    one = 200'sd1;
    q = 1'b0;
    v = 200'(a & lmask(w));
    if (sg && a[w-1]) v = v - (one <<< w);
    if (s >= 0) begin
      t = v <<< s;
      if (sat) begin
        hi = sg ? (one <<< (w-1)) - one : (one <<< w) - one;
        lo = sg ? -(one <<< (w-1)) : '0;
        if (t > hi) begin t = hi; q = 1'b1; end
        else if (t < lo) begin t = lo; q = 1'b1; end
      end
    end else begin
      m = -int'(s);
      if (rnd) t = (v + (one <<< (m-1))) >>> m;
      else     t = v >>> m;
    end
    r = 64'(t) & lmask(w);
  endfunction

  function automatic void ref_vec(input int sz, input bit sg, input bit rnd, input bit sat, input bit half,
                                  input logic [127:0] a, input logic [127:0] b,
                                  output logic [127:0] r, output bit q);
    int w, nl;
    logic [63:0] lr;
    bit lq;
    w = 8 << sz;
    nl = 128 / w;
    r = '0;
    q = 1'b0;
    for (int i = 0; i < nl; i++) begin
      if (!(half && i >= nl/2)) begin
        ref_lane(w, 64'(a >> (i*w)), 8'(b >> (i*w)), sg, rnd, sat, lr, lq);
        r = r | (128'(lr) << (i*w));
        q = q | lq;
      end
    end
  endfunction

  function automatic logic [63:0] pick(input int w, input int sel, input int seed);
    logic [63:0] mk;
    mk = lmask(w);
    case (sel % 6)
      0: return 64'd0;
      1: return mk >> 1;
      2: return 64'd1 << (w-1);
      3: return mk;
      4: return 64'd1;
      default: return (64'h9E37_79B9_7F4A_7C15 * 64'(seed + 1)) & mk;
    endcase
  endfunction

  task automatic apply(input int sz, input bit sg, input bit rnd, input bit sat, input bit half,
                       input bit clr, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    lane_size = 2'(sz); is_signed = sg; round_en = rnd; sat_en = sat;
    half_form = half; sat_clear = clr; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clear = 1'b0;
  endtask

  initial begin
    logic [127:0] a, b, er, held;
    bit eq;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 R10: reset state
    check(out_valid == 1'b0 && sat_pulse == 1'b0, "R10 reset valid/pulse", {126'd0, out_valid, sat_pulse}, '0);
    check(result == '0, "R11 reset result", result, '0);
    check(sat_sticky == 1'b0, "R11 reset sticky", 128'(sat_sticky), '0);

    // R6 R11: unsigned byte 0xFF << 1 clamps
    apply(0, 0, 0, 1, 0, 0, 128'hFF, 128'h01);
    check(result == 128'hFF, "R6 unsigned clamp", result, 128'hFF);
    check(sat_pulse && sat_sticky, "R11 pulse sets sticky", {126'd0, sat_pulse, sat_sticky}, 128'd3);
    // R11: non-saturating op keeps sticky
    apply(0, 0, 0, 1, 0, 0, 128'h12, 128'h00);
    check(!sat_pulse && sat_sticky, "R11 sticky holds", {126'd0, sat_pulse, sat_sticky}, 128'd1);
    held = result;
    // R10: idle keeps result, out_valid low
    @(negedge clk);
    check(!out_valid && result == held, "R10 idle hold", result, held);
    // R11: clear while idle
    sat_clear = 1'b1;
    @(negedge clk);
    sat_clear = 1'b0;
    check(!sat_sticky, "R11 clear", 128'(sat_sticky), '0);
    // R11: clear together with a clamp keeps flag set
    apply(3, 1, 0, 1, 0, 1, {64'd0, 64'h4000_0000_0000_0000}, {64'd0, 64'd1});
    check(sat_sticky && result == {64'd0, 64'h7FFF_FFFF_FFFF_FFFF}, "R11 R6 clear+clamp", result, {64'd0, 64'h7FFF_FFFF_FFFF_FFFF});
    // R7: zero input with max amount never saturates
    apply(2, 1, 0, 1, 0, 1, '0, {4{32'h0000_007F}});
    check(!sat_pulse && result == '0, "R7 zero input", result, '0);
    // R5: unsigned 64-bit rounding carry kept
    apply(3, 0, 1, 0, 0, 0, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {64'h0000_0000_0000_00C0, 64'h0000_0000_0000_00FF});
    check(result == {64'd1, 64'h8000_0000_0000_0000}, "R5 carry kept", result, {64'd1, 64'h8000_0000_0000_0000});

    // Sweep: every width, every mode, every amount
    for (int sz = 0; sz < 4; sz++) begin
      for (int mode = 0; mode < 8; mode++) begin
        for (int amt = -128; amt < 128; amt++) begin
          int w, nl;
          bit sg, rnd, sat, half, eq_q;
          w = 8 << sz; nl = 128 / w;
          sg = mode[0]; rnd = mode[1]; sat = mode[2];
          half = ((amt + 128) % 5) == 0;
          a = '0; b = '0;
          for (int i = 0; i < nl; i++) begin
            logic [63:0] bl;
            a = a | (128'(pick(w, i + amt + 128, i * 977 + amt + mode * 31)) << (i*w));
            bl = ((64'hA5C3_0F1E_D2B4_9687 * 64'(i + mode + 3)) & lmask(w) & ~64'hFF) | 64'(8'(amt));
            b = b | (128'(bl) << (i*w));
          end
          ref_vec(sz, sg, rnd, sat, half, a, b, er, eq_q);
          apply(sz, sg, rnd, sat, half, 0, a, b);
          if (amt == 0) tag = "R2 zero R1 R9";
          else if (amt < 0) tag = rnd ? "R5 round R1 R9" : "R4 R2 trunc R1 R9";
          else tag = sat ? "R6 sat R1 R9" : "R3 wrap R1 R9";
          if (half) tag = {tag, " R8"};
          eq = (result == er);
          check(eq && out_valid, tag, result, er);
          check(sat_pulse == eq_q, "R6 R7 R8 pulse", 128'(sat_pulse), 128'(eq_q));
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule